// File: doc/BRIEF.md
# Branch Direction Predictor with Target Cache

This block gives the fetch stage a next-fetch prediction for each fetched address. A table of 2048 two-bit saturating counters predicts the branch direction. A 256-entry direct-mapped target cache supplies the taken target. When the condition code that a branch tests has already been computed, the fetch stage passes in its real value, and that value takes the place of the counter guess.

Along with the direction and target, the block reports how many fetch bubbles the prediction costs:
- none for a predicted-taken branch that hits in the target cache, and for a not-taken prediction;
- one for a predicted-taken branch that misses;
- two in the cycle after the branch unit reports a misprediction.

The branch unit trains the block through an update port. Each resolved branch adjusts its counter. A taken branch writes its target into the cache. A not-taken branch removes its own cache entry.

The prediction is registered and appears one clock after the fetch request. The counter table and the target cache are read before the clock edge, so an update at the same edge is visible only to fetches in later cycles.

Top module: `bpred_top`

## Requirements
- R1: After reset, `pred_valid`, `pred_taken`, `pred_hit` and `pred_bubbles` are 0. Every counter holds 1 (weakly not-taken) and every target-cache entry is empty.
- R2: The counter for a fetch is selected by PC bits [12:2]. The predicted direction is taken when that counter is 2 or 3.
- R3: On `upd_valid` the counter at `upd_pc[12:2]` moves up by one when `upd_taken` is 1 and down by one otherwise. It stays at 3 and at 0 when it would leave that range.
- R4: The target cache is indexed by PC bits [9:2] and keeps PC bits [17:10] as a partial tag. A lookup hits only when the entry is valid and its tag equals the fetch PC bits [17:10].
- R5: An update with `upd_taken` = 1 writes the entry at `upd_pc[9:2]`: valid, with tag `upd_pc[17:10]` and target `upd_target`. This replaces any previous content.
- R6: An update with `upd_taken` = 0 clears the valid bit of the entry at `upd_pc[9:2]` only when that entry is valid and its tag matches `upd_pc[17:10]`. Otherwise the entry is left as it was.
- R7: When `cc_ready` is 1 with a fetch, `cc_taken` is the predicted direction and the counter value is not used.
- R8: For a valid fetch:
  - predicted taken with a cache hit gives `pred_bubbles` = 0 and `pred_target` = cached target;
  - predicted taken with a miss gives `pred_bubbles` = 1 and `pred_target` = PC + 4;
  - predicted not-taken gives `pred_bubbles` = 0 and `pred_target` = PC + 4.
- R9: When `upd_valid` and `upd_mispred` are both 1, `pred_bubbles` is 2 in the next cycle, whatever the fetch predicts.
- R10: The outputs for a fetch appear one cycle after it. `pred_valid` follows `fetch_valid`, and `pred_taken` and `pred_hit` are 0 when there is no fetch. A fetch in the same cycle as an update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_pc | input | 32 | Fetch address |
| cc_ready | input | 1 | Condition code for this branch is already computed |
| cc_taken | input | 1 | Actual outcome given by the computed condition code |
| upd_valid | input | 1 | Branch unit resolves a branch |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved taken target |
| upd_mispred | input | 1 | The resolved branch was mispredicted |
| pred_valid | output | 1 | Prediction is valid |
| pred_taken | output | 1 | Predicted direction |
| pred_hit | output | 1 | Target cache hit |
| pred_target | output | 32 | Predicted next fetch address |
| pred_bubbles | output | 2 | Fetch bubbles caused by this prediction |

## Verification
On every cycle the assertions check the following:
- a single bubble only ever follows a taken prediction;
- a taken hit outside a misprediction costs nothing;
- a misprediction report gives two bubbles on the next cycle;
- a computed condition code decides the direction;
- a not-taken prediction falls through to PC + 4.

Counter saturation, partial-tag aliasing, replacement, and invalidation by a matching not-taken branch all depend on training history. Only the bench's scenarios show these. The bench runs them against its own model of the tables.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'd1;
    localparam ctr_t CTR_MAX     = 2'd3;
    localparam ctr_t CTR_MIN     = 2'd0;

    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        ctr_t r;
        if (taken) r = (c == CTR_MAX) ? c : c + 2'd1;
        else       r = (c == CTR_MIN) ? c : c - 2'd1;
        return r;
    endfunction
endpackage

// File: rtl/bpred_pht.sv
module bpred_pht
    import bpred_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t ctr_q [ENTRIES];
    ctr_t wr_ctr_d;

    always_comb begin
        rd_ctr   = ctr_q[rd_idx];
        wr_ctr_d = ctr_step(ctr_q[wr_idx], wr_taken);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_ctr_d;
        end
    end
endmodule

// File: rtl/bpred_btc.sv
module bpred_btc #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 8,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    input  logic [PC_W-1:0]  wr_target
);
    localparam int ENTRIES = 1 << IDX_W;

    logic             vld_q [ENTRIES];
    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [PC_W-1:0]  tgt_q [ENTRIES];

    logic alloc_d;
    logic kill_d;

    always_comb begin
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_target = tgt_q[rd_idx];
        alloc_d   = wr_en && wr_taken;
        kill_d    = wr_en && !wr_taken && vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
        end else if (alloc_d) begin
            vld_q[wr_idx] <= 1'b1;
        end else if (kill_d) begin
            vld_q[wr_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_d) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end
endmodule

// File: rtl/bpred_top.sv
module bpred_top
    import bpred_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PHT_IDX_W = 11,
    parameter int BTC_IDX_W = 8,
    parameter int TAG_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            cc_ready,
    input  logic            cc_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_mispred,
    output logic            pred_valid,
    output logic            pred_taken,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_target,
    output logic [1:0]      pred_bubbles
);
    localparam int              PC_LSB   = 2;
    localparam int              TAG_LSB  = PC_LSB + BTC_IDX_W;
    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);
    localparam logic [1:0]      BUB_NONE = 2'd0;
    localparam logic [1:0]      BUB_MISS = 2'd1;
    localparam logic [1:0]      BUB_FLUSH = 2'd2;

    typedef struct packed {
        logic            valid;
        logic            taken;
        logic            hit;
        logic [PC_W-1:0] target;
        logic [1:0]      bubbles;
    } pred_t;

    pred_t out_d, out_q;

    ctr_t            f_ctr;
    logic            f_hit;
    logic [PC_W-1:0] f_tgt;
    logic            f_dir;

    bpred_pht #(.IDX_W(PHT_IDX_W)) pht_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_pc[PC_LSB +: PHT_IDX_W]),
        .rd_ctr   (f_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[PC_LSB +: PHT_IDX_W]),
        .wr_taken (upd_taken)
    );

    bpred_btc #(.IDX_W(BTC_IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) btc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (fetch_pc[PC_LSB +: BTC_IDX_W]),
        .rd_tag    (fetch_pc[TAG_LSB +: TAG_W]),
        .rd_hit    (f_hit),
        .rd_target (f_tgt),
        .wr_en     (upd_valid),
        .wr_idx    (upd_pc[PC_LSB +: BTC_IDX_W]),
        .wr_tag    (upd_pc[TAG_LSB +: TAG_W]),
        .wr_taken  (upd_taken),
        .wr_target (upd_target)
    );

    always_comb begin
        f_dir         = cc_ready ? cc_taken : f_ctr[1];
        out_d.valid   = fetch_valid;
        out_d.taken   = fetch_valid && f_dir;
        out_d.hit     = fetch_valid && f_hit;
        out_d.target  = (f_dir && f_hit) ? f_tgt : fetch_pc + INSN_BYTES;
        if (upd_valid && upd_mispred)           out_d.bubbles = BUB_FLUSH;
        else if (fetch_valid && f_dir && !f_hit) out_d.bubbles = BUB_MISS;
        else                                    out_d.bubbles = BUB_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pred_valid   = out_q.valid;
    assign pred_taken   = out_q.taken;
    assign pred_hit     = out_q.hit;
    assign pred_target  = out_q.target;
    assign pred_bubbles = out_q.bubbles;
endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_valid,
    input logic [PC_W-1:0] fetch_pc,
    input logic            cc_ready,
    input logic            cc_taken,
    input logic            upd_valid,
    input logic            upd_mispred,
    input logic            pred_valid,
    input logic            pred_taken,
    input logic            pred_hit,
    input logic [PC_W-1:0] pred_target,
    input logic [1:0]      pred_bubbles
);
    assert_miss_bubble_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_bubbles == 2'd1) |-> pred_taken);

    assert_hit_no_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_taken && pred_hit && pred_bubbles != 2'd2) |-> pred_bubbles == 2'd0);

    assert_mispred_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_mispred) |=> pred_bubbles == 2'd2);

    assert_cc_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && cc_ready) |=> pred_taken == $past(cc_taken));

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (!pred_valid && !pred_taken && !pred_hit));

    assert_fallthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> (pred_taken || pred_target == $past(fetch_pc) + PC_W'(4)));
endmodule

bind bpred_top bpred_chk #(.PC_W(PC_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_pc     (fetch_pc),
    .cc_ready     (cc_ready),
    .cc_taken     (cc_taken),
    .upd_valid    (upd_valid),
    .upd_mispred  (upd_mispred),
    .pred_valid   (pred_valid),
    .pred_taken   (pred_taken),
    .pred_hit     (pred_hit),
    .pred_target  (pred_target),
    .pred_bubbles (pred_bubbles)
);

// File: tb/bpred_top_tb_top.sv
module bpred_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        cc_ready = 1'b0;
    logic        cc_taken = 1'b0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_mispred = 1'b0;
    logic        pred_valid, pred_taken, pred_hit;
    logic [31:0] pred_target;
    logic [1:0]  pred_bubbles;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [1:0]  m_ctr [2048];
    logic        m_vld [256];
    logic [7:0]  m_tag [256];
    logic [31:0] m_tgt [256];

    always #5ns clk = ~clk;

    bpred_top dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .cc_ready(cc_ready), .cc_taken(cc_taken), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target), .upd_mispred(upd_mispred),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hit(pred_hit),
        .pred_target(pred_target), .pred_bubbles(pred_bubbles)
    );

    function automatic logic [31:0] mk_pc(logic [7:0] tag, logic [7:0] idx);
        return {14'd0, tag, idx, 2'b00};
    endfunction

    function automatic logic [1:0] sat(logic [1:0] c, logic t);
        if (t) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(string req, bit fv, logic [31:0] fpc, bit ccr, bit cct,
                        bit uv, logic [31:0] upc, bit ut, logic [31:0] utg, bit um);
        logic dir, hit;
        logic [31:0] tgt;
        logic [1:0] bub;
        fetch_valid = fv; fetch_pc = fpc; cc_ready = ccr; cc_taken = cct;
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg; upd_mispred = um;
        dir = ccr ? cct : m_ctr[fpc[12:2]][1];
        hit = m_vld[fpc[9:2]] && (m_tag[fpc[9:2]] == fpc[17:10]);
        tgt = (dir && hit) ? m_tgt[fpc[9:2]] : fpc + 32'd4;
        bub = (uv && um) ? 2'd2 : (fv && dir && !hit) ? 2'd1 : 2'd0;
        @(posedge clk);
        if (uv) begin
            m_ctr[upc[12:2]] = sat(m_ctr[upc[12:2]], ut);
            if (ut) begin
                m_vld[upc[9:2]] = 1'b1; m_tag[upc[9:2]] = upc[17:10]; m_tgt[upc[9:2]] = utg;
            end else if (m_vld[upc[9:2]] && m_tag[upc[9:2]] == upc[17:10]) begin
                m_vld[upc[9:2]] = 1'b0;
            end
        end
        @(negedge clk);
        check(req, {pred_valid, pred_taken, pred_hit, pred_bubbles},
                   {fv, fv & dir, fv & hit, bub});
        if (fv) check(req, pred_target, tgt);
    endtask

    task automatic fetch(string req, logic [31:0] pc);
        step(req, 1, pc, 0, 0, 0, '0, 0, '0, 0);
    endtask

    task automatic train(logic [31:0] pc, bit t, logic [31:0] tg);
        step("R3", 0, '0, 0, 0, 1, pc, t, tg, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, c;
        void'($urandom(32'd1234));
        for (int i = 0; i < 2048; i++) m_ctr[i] = 2'd1;
        for (int i = 0; i < 256; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the outputs and in the tables
        check("R1", {pred_valid, pred_taken, pred_hit, pred_bubbles}, 5'd0);
        fetch("R1", mk_pc(8'h12, 8'h34));

        a = mk_pc(8'h05, 8'h10);
        b = mk_pc(8'h06, 8'h10); // same cache index, other tag (R4)
        c = mk_pc(8'h05, 8'h11);
        // R3: saturate up, then one not-taken keeps predicting taken
        repeat (5) train(a, 1, 32'h0000_8000);
        fetch("R5", a);                 // taken hit, target from cache
        train(a, 0, 32'h0);             // invalidates matching entry (R6), ctr 3->2
        fetch("R6", a);                 // taken, miss, 1 bubble
        fetch("R2", c);                 // untrained neighbour: not taken
        // R4: alias with other tag misses
        train(a, 1, 32'h0000_9000);
        fetch("R4", b);
        // R6: not-taken with non-matching tag leaves entry
        train(b, 0, 32'h0);
        fetch("R6", a);
        // R3: saturate low
        repeat (5) train(c, 0, 32'h0);
        train(c, 1, 32'h0000_7000);
        fetch("R3", c);
        // R7: computed condition code overrides counters both ways
        step("R7", 1, c, 1, 1, 0, '0, 0, '0, 0);
        step("R7", 1, a, 1, 0, 0, '0, 0, '0, 0);
        // R9: mispredict gives two bubbles
        step("R9", 1, a, 0, 0, 1, c, 0, '0, 1);
        step("R9", 0, '0, 0, 0, 1, a, 1, 32'h0000_9000, 1);
        // R10: fetch in same cycle as update sees old state
        step("R10", 1, c, 0, 0, 1, c, 1, 32'h0000_7100, 0);
        fetch("R10", c);
        step("R10", 0, '0, 0, 0, 0, '0, 0, '0, 0);

        // R2 R8: constrained random over a small aliasing pool
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ix[4];
            logic [31:0] fpc, upc;
            ix[0] = 8'h03; ix[1] = 8'h07; ix[2] = 8'h28; ix[3] = 8'hC8;
            fpc = mk_pc(($urandom % 2) ? 8'h05 : 8'h09, ix[$urandom % 4]);
            upc = mk_pc(($urandom % 2) ? 8'h05 : 8'h09, ix[$urandom % 4]);
            step("R8", ($urandom % 4) != 0, fpc, ($urandom % 5) == 0, $urandom % 2,
                 ($urandom % 2) == 1, upc, ($urandom % 3) != 0,
                 {16'd0, $urandom % 65536} & 32'hFFFF_FFFC, ($urandom % 8) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule